// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Read-Out Controller

This block is the digital side of a converter's three-wire read-out port. It runs an endless cycle of converting, sleeping and sending the result. While a conversion runs, or while the result waits, a host that pulls chip select low sees a live ready flag on the data pin. The first rising serial clock edge with chip select low starts the transfer. The 32-bit frame then goes out most significant bit first, with one new bit after each falling clock edge.

The serial clock comes from one of two places. The host can drive it, or the block can make it by dividing the conversion timebase by eight. The block picks the source at reset and again on every chip-select falling edge by looking at the level on the clock pin. A high or floating pin selects the internal clock, and a low pin selects the host's clock. Raising chip select during a transfer cuts the transfer short and starts a new conversion at once. If chip select is tied low, the block converts and sends frames with no gaps.

All pin inputs pass through two-flop synchronizers into the system clock. The conversion timebase arrives as a one-cycle tick in the system clock domain.

Top module: `dsadc_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `state` is 2'b00 (convert), and `sdo_oe` and `sck_oe` are both 0 while `cs_n` is high.
- R2: A conversion lasts CONV_TICKS timebase ticks and is followed by `state` 2'b01 (sleep). Sleep holds for as long as `cs_n` is high, and clock edges on `sck_i` have no effect during that time.
- R3: `sdo_oe` is 1 while `cs_n` is low and 0 while it is high, after the two-stage synchronizer delay.
- R4: With `cs_n` low, `sdo` is 1 in convert and 0 in sleep. This is the ready flag.
- R5: In sleep with `cs_n` low, the first rising serial clock edge moves `state` to 2'b10 (data). The frame is 32 bits, sent first to last: a 0 (the ready flag), then `conv_word[30]` down to `conv_word[0]`. The word is captured when the conversion ends. Each bit after the first takes its place after a falling serial clock edge, so it is valid at the next rising edge.
- R6: After the 32nd falling serial clock edge, `state` returns to convert and `sdo` reads 1.
- R7: A rise of `cs_n` while `state` is data aborts the transfer and returns `state` to convert at once.
- R8: The clock source is chosen at reset release and at every falling edge of `cs_n`. A high `sck_i` selects the internal clock. A low `sck_i` selects the external clock, and then `sck_oe` stays 0.
- R9: In internal mode with `cs_n` low, `sck_oe` and `sck_pu` are 1. `sck_o` is low outside sleep and data. In those two states `sck_o` has a period of 8 timebase ticks, and it starts low.
- R10: With `cs_n` held low from reset onward, frames and conversions follow one another with no host action besides the clock. Each frame carries the word from the conversion just finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_tick | input | 1 | One-cycle pulse per conversion timebase period |
| conv_word | input | 31 | Result bits sent after the ready flag, captured when a conversion ends |
| cs_n | input | 1 | Active-low chip select |
| sck_i | input | 1 | Level on the serial clock pin |
| sdo | output | 1 | Serial data and ready flag |
| sdo_oe | output | 1 | Data pin drive enable; 0 means high impedance |
| sck_o | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Serial clock pin drive enable |
| sck_pu | output | 1 | Weak pull-up enable for the clock pin |
| state | output | 2 | 00 convert, 01 sleep, 10 data |

## Verification
The hardest case to reach is a change of clock source in the middle of the cycle. The host has to land a chip-select falling edge at a chosen `sck_i` level, and the block then has to switch between driving and sampling the pin without a false edge. The stimulus raises chip select, parks `sck_i` at the new level and lowers chip select again. It does this once while sleeping, so that an internal-clock frame runs on its own, and once more to fall back to the external clock. A second reset with chip select already low reaches the gap-free mode, where the choice made at power-up alone sets the clock source.

// File: rtl/dsadc_port_pkg.sv
// Package: shared state encoding for the serial read-out controller.
// Assumes: two-bit state field visible at the top-level port.
package dsadc_port_pkg;
    typedef enum logic [1:0] {
        ST_CONV  = 2'b00,
        ST_SLEEP = 2'b01,
        ST_DATA  = 2'b10
    } port_state_e;
endpackage

// File: rtl/dsadc_sync.sv
// Multi-bit level synchronizer: a chain of STAGES flops per bit.
// Assumes: each bit is an independent slow level; INIT gives the reset level.
module dsadc_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dsadc_sckgen.sv
// Internal serial clock generator: divides the timebase tick by 2*HALF.
// Assumes: run drops to reset the phase; output starts low when run rises.
module dsadc_sckgen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic sck,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

    logic [PH_W-1:0] ph;
    logic            flip;

    assign flip    = run && tick && (ph == PH_LAST);
    assign rise_ev = flip && !sck;
    assign fall_ev = flip && sck;

    // Count ticks within a half period and toggle the clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph  <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            if (ph == PH_LAST) begin
                ph  <= '0;
                sck <= ~sck;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // R9
    sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !$past(sck)) |-> ($past(tick) && $past(run)));

    // R9
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> !sck);
endmodule

// File: rtl/dsadc_shifter.sv
// Output frame register: loads the ready flag plus result, shifts MSB first.
// Assumes: load and shift never coincide; last marks the final bit in place.
module dsadc_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-2:0] word,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    logic [W-1:0]     sreg;
    logic [CNT_W-1:0] cnt;

    // Capture a new frame or advance to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (load) begin
            sreg <= {1'b0, word};
            cnt  <= '0;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b1};
            cnt  <= cnt + 1'b1;
        end
    end

    assign msb  = sreg[W-1];
    assign last = (cnt == CNT_LAST);

    // R5
    ready_flag_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !msb);

    // R5
    no_load_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/dsadc_seq.sv
// Cycle sequencer: convert -> sleep -> data -> convert, with abort.
// Assumes: events arrive synchronous, one cycle wide; tick paces conversion.
module dsadc_seq
    import dsadc_port_pkg::*;
#(
    parameter int CONV_TICKS = 20480
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        cs_low,
    input  logic        cs_rise,
    input  logic        rise_ev,
    input  logic        fall_ev,
    input  logic        last_bit,
    output port_state_e st,
    output logic        load,
    output logic        shift
);
    localparam int CW = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CONV_TICKS - 1);

    logic [CW-1:0] cnt;

    assign load  = (st == ST_CONV) && tick && (cnt == CNT_LAST);
    assign shift = (st == ST_DATA) && fall_ev && !cs_rise;

    // Advance the state and count conversion ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_CONV;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_CONV: if (tick) begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        st  <= ST_SLEEP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SLEEP: if (cs_low && rise_ev) st <= ST_DATA;
                ST_DATA: begin
                    if (cs_rise)                  st <= ST_CONV;
                    else if (fall_ev && last_bit) st <= ST_CONV;
                end
                default: st <= ST_CONV;
            endcase
        end
    end

    // R5
    data_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && $past(st) != ST_DATA) |-> $past(st) == ST_SLEEP);

    // R2
    sleep_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && $past(st) == ST_CONV) |-> ($past(cnt) == CNT_LAST && $past(tick)));

    // R7
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && cs_rise) |=> st == ST_CONV);
endmodule

// File: rtl/dsadc_port_ctrl.sv
// Top: serial read-out controller for a delta-sigma converter.
// Synchronizes the pins, picks the clock source, drives status and data.
// Assumes: conv_tick is a one-cycle pulse; pins are slow against clk.
module dsadc_port_ctrl
    import dsadc_port_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int CONV_TICKS  = 20480,
    parameter int SCK_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_tick,
    input  logic [WORD_W-2:0] conv_word,
    input  logic              cs_n,
    input  logic              sck_i,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sck_pu,
    output logic [1:0]        state
);
    localparam int HALF  = SCK_DIV / 2;
    localparam int POR_N = SYNC_STAGES + 1;
    localparam int POR_W = $clog2(POR_N + 1);

    logic [1:0]       pins_s;
    logic             cs_s, sck_s, cs_q, sck_q;
    logic             cs_low, cs_fall, cs_rise;
    logic             mode_int, por_pend;
    logic [POR_W-1:0] por_cnt;
    logic             gen_run, gen_rise, gen_fall;
    logic             ext_rise, ext_fall, rise_ev, fall_ev;
    logic             load, shift, msb, last_bit;
    port_state_e      st;

    dsadc_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck_i}), .q(pins_s)
    );
    assign cs_s  = pins_s[1];
    assign sck_s = pins_s[0];

    // Keep the previous synchronized pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b1;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
        end
    end

    assign cs_low   = !cs_s;
    assign cs_fall  = cs_q && !cs_s;
    assign cs_rise  = !cs_q && cs_s;
    assign ext_rise = !mode_int && cs_low && sck_s && !sck_q;
    assign ext_fall = !mode_int && cs_low && !sck_s && sck_q;

    // Select the clock source at power-up settle and on chip-select falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_int <= 1'b1;
            por_pend <= 1'b1;
            por_cnt  <= '0;
        end else begin
            if (por_pend) begin
                if (por_cnt == POR_W'(POR_N)) begin
                    por_pend <= 1'b0;
                    mode_int <= sck_s;
                end else begin
                    por_cnt <= por_cnt + 1'b1;
                end
            end else if (cs_fall) begin
                mode_int <= sck_s;
            end
        end
    end

    assign gen_run = mode_int && cs_low && (st != ST_CONV);

    dsadc_sckgen #(.HALF(HALF)) u_sckgen (
        .clk(clk), .rst_n(rst_n), .run(gen_run), .tick(conv_tick),
        .sck(sck_o), .rise_ev(gen_rise), .fall_ev(gen_fall)
    );

    assign rise_ev = mode_int ? gen_rise : ext_rise;
    assign fall_ev = mode_int ? gen_fall : ext_fall;

    dsadc_seq #(.CONV_TICKS(CONV_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(conv_tick), .cs_low(cs_low),
        .cs_rise(cs_rise), .rise_ev(rise_ev), .fall_ev(fall_ev),
        .last_bit(last_bit), .st(st), .load(load), .shift(shift)
    );

    dsadc_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .word(conv_word),
        .shift(shift), .msb(msb), .last(last_bit)
    );

    assign sdo    = (st == ST_CONV) ? 1'b1 : msb;
    assign sdo_oe = cs_low;
    assign sck_oe = mode_int && cs_low;
    assign sck_pu = mode_int;
    assign state  = st;

    // R8
    mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int != $past(mode_int)) |-> ($past(cs_fall) || $past(por_pend)));

    // R6
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONV && $past(st) == ST_DATA && !$past(cs_rise)) |-> $past(last_bit));
endmodule

// File: tb/dsadc_port_ctrl_test.sv
// Scoreboard bench: the driver queues expected frame bits, the monitor
// pops one at each rising serial clock seen on the pin and compares sdo.
module dsadc_port_ctrl_test;
    localparam int CT = 16;

    logic        clk = 0, rst_n = 0, conv_tick = 0;
    logic [30:0] conv_word = '0;
    logic        cs_n = 1, sck_i = 1;
    logic        sdo, sdo_oe, sck_o, sck_oe, sck_pu;
    logic [1:0]  state;
    int          n_chk = 0, n_fail = 0, cyc = 0;
    bit          exp_q [$];
    logic        pin_prev = 1;

    dsadc_port_ctrl #(.CONV_TICKS(CT)) uut (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .conv_word(conv_word),
        .cs_n(cs_n), .sck_i(sck_i), .sdo(sdo), .sdo_oe(sdo_oe), .sck_o(sck_o),
        .sck_oe(sck_oe), .sck_pu(sck_pu), .state(state)
    );

    always #2 clk = ~clk;
    always @(posedge clk) begin
        conv_tick <= ~conv_tick;
        cyc <= cyc + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare sdo against the queue on each rising pin clock.
    always @(posedge clk) begin
        logic pin;
        pin = sck_oe ? sck_o : sck_i;
        if (pin && !pin_prev && exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            check("R5 frame bit", {31'b0, sdo}, {31'b0, e});
        end
        pin_prev <= pin;
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_frame(input logic [30:0] w, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(i == 0 ? 1'b0 : w[31-i]);
    endtask

    task automatic ext_clock(input int n);
        for (int i = 0; i < n; i++) begin
            sck_i = 1; clks(8);
            sck_i = 0; clks(8);
        end
    endtask

    task automatic wait_state(input logic [1:0] s, input string req);
        int k = 0;
        while (state !== s && k < 2000) begin clks(1); k++; end
        check(req, {30'b0, state}, {30'b0, s});
    endtask

    task automatic do_reset(input logic cs_lvl, input logic sck_lvl);
        rst_n = 0; cs_n = cs_lvl; sck_i = sck_lvl;
        clks(4); rst_n = 1; clks(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t1, t2;
        conv_word = 31'h5EAD_BEEF;
        clks(1);
        do_reset(1'b1, 1'b0);
        // R1 reset state
        check("R1 state", {30'b0, state}, 32'h0);
        check("R1 sdo_oe", {31'b0, sdo_oe}, 32'h0);
        check("R1 sck_oe", {31'b0, sck_oe}, 32'h0);
        // R4 ready flag high during convert, R3 enable follows cs
        cs_n = 0; clks(4);
        check("R3 oe low cs", {31'b0, sdo_oe}, 32'h1);
        check("R4 eoc convert", {31'b0, sdo}, 32'h1);
        wait_state(2'b01, "R2 sleep after convert");
        clks(2);
        check("R4 eoc ready", {31'b0, sdo}, 32'h0);
        // R2 clock ignored while cs high
        cs_n = 1; clks(4);
        check("R3 oe high cs", {31'b0, sdo_oe}, 32'h0);
        ext_clock(3);
        check("R2 sleep kept", {30'b0, state}, 32'h1);
        // R5 full external frame, R6 return to convert
        push_frame(conv_word, 32);
        cs_n = 0; clks(4);
        ext_clock(1);
        check("R5 data state", {30'b0, state}, 32'h2);
        ext_clock(31);
        clks(2);
        check("R6 back to convert", {30'b0, state}, 32'h0);
        check("R6 sdo high", {31'b0, sdo}, 32'h1);
        check("R5 queue drained", exp_q.size(), 0);
        // R7 abort after 8 bits
        conv_word = 31'h1234_5678;
        wait_state(2'b01, "R2 sleep second");
        push_frame(conv_word, 8);
        ext_clock(8);
        check("R7 still data", {30'b0, state}, 32'h2);
        cs_n = 1; clks(4);
        check("R7 aborted", {30'b0, state}, 32'h0);
        // R8/R9 internal clock frame
        conv_word = 31'h1357_9BDF;
        sck_i = 1;
        wait_state(2'b01, "R2 sleep third");
        push_frame(conv_word, 32);
        cs_n = 0; clks(5);
        check("R9 sck_oe", {31'b0, sck_oe}, 32'h1);
        check("R9 sck_pu", {31'b0, sck_pu}, 32'h1);
        @(posedge sck_o); t1 = cyc;
        @(posedge sck_o); t2 = cyc;
        check("R9 period", t2 - t1, 16);
        clks(1);
        wait_state(2'b00, "R6 internal frame end");
        check("R9 queue drained", exp_q.size(), 0);
        clks(2);
        check("R9 sck low in convert", {31'b0, sck_o}, 32'h0);
        // R8 back to external
        cs_n = 1; sck_i = 0; clks(4);
        cs_n = 0; clks(5);
        check("R8 external chosen", {31'b0, sck_oe}, 32'h0);
        check("R8 pullup off", {31'b0, sck_pu}, 32'h0);
        cs_n = 1; clks(4);
        // R10 continuous with cs tied low
        conv_word = 31'h4000_0001;
        do_reset(1'b0, 1'b0);
        clks(4);
        check("R8 power-up external", {31'b0, sck_oe}, 32'h0);
        wait_state(2'b01, "R10 first sleep");
        push_frame(conv_word, 32);
        ext_clock(32);
        conv_word = 31'h7FFF_FFFE;
        clks(2);
        check("R10 convert again", {30'b0, state}, 32'h0);
        wait_state(2'b01, "R10 second sleep");
        push_frame(conv_word, 32);
        ext_clock(32);
        clks(2);
        check("R10 frames drained", exp_q.size(), 0);
        check("R10 convert third", {30'b0, state}, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule